// File: doc/BRIEF.md
# Strobe-Selected Register Transfer

The block holds a bank of four 8-bit source registers and one 8-bit destination register. Four timing strobes pick which source is copied into the destination. At most one strobe should be high in any cycle. The strobes are encoded by OR gates into a two-bit multiplexer select and a destination load enable. A binary select and a separate load pulse are therefore not needed: the strobe that is high names both the source and the moment of the transfer.

Each source register has its own write enable. All source registers share one data input, so a surrounding sequencer or a test can preset their values. When two or more strobes are high in the same cycle, the block raises an error flag for that cycle and does not load the destination. The encoded select and load enable are also brought out as ports.

The reset input is asynchronous and active low. It takes effect at once and is released in step with the clock through a two-stage synchronizer.

Top module: `strobe_xfer`

## Requirements
- R1: While reset is active, all four source registers and the destination register are cleared to zero. After release, `dst_q` reads 0, and a transfer from any source with no prior write delivers 0.
- R2: When exactly one strobe `t_strb[k]` is high at a rising edge, `dst_q` holds the value of source register k from the next cycle on. Bit 0 of `t_strb` selects source 0, and bit 3 selects source 3.
- R3: `mux_sel[0]` equals `t_strb[1] | t_strb[3]`, and `mux_sel[1]` equals `t_strb[2] | t_strb[3]`. This holds in the same cycle and for any strobe pattern. With one strobe high, `mux_sel` is the index of that strobe.
- R4: `dst_ld` is high in the same cycle as exactly one strobe is high. It is low when no strobe is high.
- R5: With all strobes low, `dst_q` keeps its value.
- R6: When two or more strobes are high, `strb_err` is high in that cycle, `dst_ld` is low, and `dst_q` keeps its value. With zero or one strobe high, `strb_err` is low.
- R7: At a rising edge, every source register whose `src_ld` bit is high (bit k for source k) takes `src_din`. Several registers may load in the same edge. Any source whose bit is low keeps its value.
- R8: If a source is written in the same cycle as a transfer from that source, the destination receives the source value from before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| src_ld | input | 4 | Per-source write enable, bit k writes source k |
| src_din | input | 8 | Shared write data for the source registers |
| t_strb | input | 4 | One-hot timing strobes, bit k transfers source k |
| mux_sel | output | 2 | Encoded multiplexer select |
| dst_ld | output | 1 | Destination load enable |
| strb_err | output | 1 | More than one strobe high in this cycle |
| dst_q | output | 8 | Destination register contents |

## Verification
Two things can fall on the same edge: a write into a source register and a transfer out of that same register. The bench provokes this on purpose for every index, and its random traffic also raises write enables and strobes together. A reference model updates the destination from the source values before the write, then applies the writes. The outcome is judged by comparing `dst_q` against that model one cycle later. The same model also covers illegal multi-strobe cycles, where the destination must hold whatever writes happen alongside.

// File: rtl/strobe_xfer_pkg.sv
package strobe_xfer_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned N_SRC  = 4;
  localparam int unsigned SEL_W  = (N_SRC > 1) ? $clog2(N_SRC) : 1;

  typedef logic [DATA_W-1:0] word_t;
  typedef logic [SEL_W-1:0]  sel_t;
endpackage

// File: rtl/strobe_xfer_rst_sync.sv
module strobe_xfer_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_nxt;

  always_comb begin
    chain_nxt = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= chain_nxt;
  end

  assign rst_no = chain_q[STAGES-1];
endmodule

// File: rtl/strobe_xfer_src_bank.sv
module strobe_xfer_src_bank
  import strobe_xfer_pkg::*;
#(
  parameter int unsigned W = DATA_W,
  parameter int unsigned N = N_SRC
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N-1:0]        wr_en,
  input  logic [W-1:0]        wr_data,
  output logic [N-1:0][W-1:0] src_q
);
  logic [N-1:0][W-1:0] src_nxt;

  for (genvar k = 0; k < N; k++) begin : g_src
    always_comb begin
      src_nxt[k] = wr_en[k] ? wr_data : src_q[k];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) src_q[k] <= '0;
      else        src_q[k] <= src_nxt[k];
    end

    // R7: an enabled write lands in the next cycle
    p_src_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en[k] |=> src_q[k] == $past(wr_data));
    // R7: an unselected source keeps its value
    p_src_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en[k] |=> $stable(src_q[k]));
  end
endmodule

// File: rtl/strobe_xfer_encoder.sv
module strobe_xfer_encoder
  import strobe_xfer_pkg::*;
#(
  parameter int unsigned N  = N_SRC,
  parameter int unsigned SW = SEL_W
) (
  input  logic [N-1:0]  strb,
  output logic [SW-1:0] sel,
  output logic          ld_en,
  output logic          multi
);
  // Each select bit is the OR of the strobes whose index has that bit set
  for (genvar b = 0; b < SW; b++) begin : g_sel
    always_comb begin
      sel[b] = 1'b0;
      for (int k = 0; k < N; k++) begin
        if (((k >> b) & 1) == 1) sel[b] = sel[b] | strb[k];
      end
    end
  end

  logic seen;
  always_comb begin
    seen  = 1'b0;
    multi = 1'b0;
    for (int k = 0; k < N; k++) begin
      multi = multi | (seen & strb[k]);
      seen  = seen | strb[k];
    end
    ld_en = seen & ~multi;
  end
endmodule

// File: rtl/strobe_xfer_dest.sv
module strobe_xfer_dest
  import strobe_xfer_pkg::*;
#(
  parameter int unsigned W  = DATA_W,
  parameter int unsigned N  = N_SRC,
  parameter int unsigned SW = SEL_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SW-1:0]       sel,
  input  logic                ld_en,
  input  logic [N-1:0][W-1:0] src_q,
  output logic [W-1:0]        dst_q
);
  logic [W-1:0] mux_out;
  logic [W-1:0] dst_nxt;

  always_comb begin
    mux_out = src_q[sel];
    dst_nxt = ld_en ? mux_out : dst_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dst_q <= '0;
    else        dst_q <= dst_nxt;
  end

  // R2: a load captures the multiplexer output
  p_dst_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |=> dst_q == $past(mux_out));
  // R5: no load, no change
  p_dst_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_en |=> $stable(dst_q));
endmodule

// File: rtl/strobe_xfer.sv
module strobe_xfer
  import strobe_xfer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  src_ld,
  input  logic [DATA_W-1:0] src_din,
  input  logic [N_SRC-1:0]  t_strb,
  output logic [SEL_W-1:0]  mux_sel,
  output logic              dst_ld,
  output logic              strb_err,
  output logic [DATA_W-1:0] dst_q
);
  logic rst_n_s;
  logic [N_SRC-1:0][DATA_W-1:0] src_q;

  strobe_xfer_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_ni(rst_n), .rst_no(rst_n_s)
  );

  strobe_xfer_src_bank #(.W(DATA_W), .N(N_SRC)) u_src (
    .clk(clk), .rst_n(rst_n_s), .wr_en(src_ld), .wr_data(src_din), .src_q(src_q)
  );

  strobe_xfer_encoder #(.N(N_SRC), .SW(SEL_W)) u_enc (
    .strb(t_strb), .sel(mux_sel), .ld_en(dst_ld), .multi(strb_err)
  );

  strobe_xfer_dest #(.W(DATA_W), .N(N_SRC), .SW(SEL_W)) u_dst (
    .clk(clk), .rst_n(rst_n_s), .sel(mux_sel), .ld_en(dst_ld),
    .src_q(src_q), .dst_q(dst_q)
  );

  // R3: a lone strobe is the one the select points at
  p_sel_index_r3: assert property (@(posedge clk) disable iff (!rst_n_s)
    $onehot(t_strb) |-> t_strb[mux_sel]);
  // R4: a lone strobe always loads
  p_ld_single_r4: assert property (@(posedge clk) disable iff (!rst_n_s)
    $onehot(t_strb) |-> dst_ld);
  // R6: several strobes raise the flag and block the load
  p_err_multi_r6: assert property (@(posedge clk) disable iff (!rst_n_s)
    ($countones(t_strb) > 1) |-> (strb_err && !dst_ld));
  // R6: destination untouched after an illegal cycle
  p_err_hold_r6: assert property (@(posedge clk) disable iff (!rst_n_s)
    strb_err |=> $stable(dst_q));
endmodule

// File: tb/strobe_xfer_tb.sv
module strobe_xfer_tb;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] src_ld;
  logic [7:0] src_din;
  logic [3:0] t_strb;
  logic [1:0] mux_sel;
  logic       dst_ld;
  logic       strb_err;
  logic [7:0] dst_q;

  int checks = 0;
  int failures = 0;
  logic [7:0] src_m [4];
  logic [7:0] dst_m;

  always #(CLK_PERIOD/2) clk = ~clk;

  strobe_xfer u_dut (
    .clk(clk), .rst_n(rst_n), .src_ld(src_ld), .src_din(src_din),
    .t_strb(t_strb), .mux_sel(mux_sel), .dst_ld(dst_ld),
    .strb_err(strb_err), .dst_q(dst_q)
  );

  function automatic int ones(input logic [3:0] s);
    int n = 0;
    for (int k = 0; k < 4; k++) n += s[k];
    return n;
  endfunction

  function automatic logic [1:0] exp_sel(input logic [3:0] s);
    return {s[2] | s[3], s[1] | s[3]};
  endfunction

  function automatic int idx_of(input logic [3:0] s);
    for (int k = 0; k < 4; k++) if (s[k]) return k;
    return 0;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One clock cycle: drive, check encoder outputs, update model, check destination
  task automatic cyc(input logic [3:0] st, input logic [3:0] sl, input logic [7:0] din,
                     input string tag);
    string t;
    @(negedge clk);
    t_strb = st; src_ld = sl; src_din = din;
    #1;
    chk("R3 mux_sel", {30'd0, mux_sel}, {30'd0, exp_sel(st)});
    chk("R4 dst_ld", {31'd0, dst_ld}, {31'd0, ones(st) == 1});
    chk("R6 strb_err", {31'd0, strb_err}, {31'd0, ones(st) > 1});
    if (ones(st) == 1) begin
      dst_m = src_m[idx_of(st)];
      t = sl[idx_of(st)] ? "R8" : "R2";
    end else begin
      t = (ones(st) > 1) ? "R6" : "R5";
    end
    for (int k = 0; k < 4; k++) if (sl[k]) src_m[k] = din;
    if (tag != "") t = tag;
    @(posedge clk);
    #1;
    chk({t, " dst_q"}, {24'd0, dst_q}, {24'd0, dst_m});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; src_ld = '0; src_din = '0; t_strb = '0;
    for (int k = 0; k < 4; k++) src_m[k] = '0;
    dst_m = '0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 dst_q in reset", {24'd0, dst_q}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 dst_q after release", {24'd0, dst_q}, 32'd0);

    // R1: unwritten sources deliver zero
    for (int k = 0; k < 4; k++) cyc(4'b0001 << k, 4'b0000, 8'hff, "R1");

    // R7: preset each source, then a shared write into two at once
    cyc(4'b0000, 4'b0001, 8'h11, "R5");
    cyc(4'b0000, 4'b0010, 8'h22, "R5");
    cyc(4'b0000, 4'b1100, 8'h3c, "R5");
    cyc(4'b0100, 4'b0000, 8'h00, "R7");
    cyc(4'b1000, 4'b0000, 8'h00, "R7");
    cyc(4'b0000, 4'b0100, 8'h33, "R5");
    for (int k = 0; k < 4; k++) cyc(4'b0001 << k, 4'b0000, 8'h00, "R2");

    // R5: idle cycles hold
    repeat (3) cyc(4'b0000, 4'b0000, 8'h55, "R5");

    // R8: write and transfer from the same source on one edge
    for (int k = 0; k < 4; k++) begin
      cyc(4'b0001 << k, 4'b0001 << k, 8'(8'h80 + k), "R8");
      cyc(4'b0001 << k, 4'b0000, 8'h00, "R8");
    end

    // R6: illegal patterns, including all four strobes
    cyc(4'b0011, 4'b0000, 8'h00, "R6");
    cyc(4'b1001, 4'b1111, 8'h9a, "R6");
    cyc(4'b1111, 4'b0000, 8'h00, "R6");
    cyc(4'b0110, 4'b0000, 8'h00, "R6");

    // Constrained random traffic
    for (int n = 0; n < 500; n++) begin
      logic [3:0] st;
      int r;
      r = int'($urandom % 8);
      if (r < 2)      st = 4'b0000;
      else if (r < 6) st = 4'b0001 << ($urandom % 4);
      else if (r == 6) begin
        int a = int'($urandom % 4);
        int b = (a + 1 + int'($urandom % 3)) % 4;
        st = (4'b0001 << a) | (4'b0001 << b);
      end else st = 4'($urandom);
      cyc(st, 4'($urandom), 8'($urandom), "");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule